// File: doc/BRIEF.md
# Receive Frame Buffer Manager with Address Copy Filter

This block sits between the byte-wide receive side of a MAC and a host-readable receive memory. Frames arrive one byte per valid cycle, marked by a first-byte and a last-byte flag. Every byte of an admitted frame goes straight into an 8 KB byte-wide RAM. The frame is written speculatively while its six destination-address bytes are still arriving. A copy filter compares those bytes with one programmable station address and with the all-ones broadcast address. When the sixth byte settles the question against the frame, the sequencer moves the write pointer back to the address where the frame began, and the rest of the frame is discarded.

A kept frame is followed in the same RAM by a four-byte status record. The record holds the 16-bit frame length (low byte first), the receive flags and the transmit flags. Both flag bytes are captured with the frame's last byte. The frame counter rises once that record has been written. The host reads the RAM through a separate read port and returns frames with a release strobe. When no frame is held, the next frame starts again at address 0. A new frame is refused, and an overflow counter is raised, when eight frames are already held or when less than one maximum frame of 4608 bytes plus a status record is left. Frames are assumed to be at most 4608 bytes long and separated by at least four idle cycles.

Top module: `rx_buffer_mgr`

## Requirements
- R1: After a clocked reset with rst_n low, frame_count and overflow_count both read 0.
- R2: The bytes of a kept frame are stored at consecutive addresses. The first frame taken while frame_count is 0 starts at address 0. Any other frame starts right after the previous frame's status record.
- R3: A frame is kept only if its first six bytes match a reference. The reference is either station_addr, taken byte by byte from bits [47:40] down to [7:0], or six bytes of 8'hFF. Any other frame is rejected.
- R4: A rejected frame leaves no kept bytes behind. The next kept frame starts at the address where the rejected frame began.
- R5: The four bytes after a kept frame's last data byte are, in order: length[7:0], length[15:8], the ind_rx_stat byte and the tx_stat byte. The length counts every byte including the address, and both status bytes are sampled with the last byte.
- R6: frame_count rises by one on the fourth clock edge after the edge that samples a kept frame's last byte.
- R7: A first byte that arrives while frame_count is 8 drops the whole frame. overflow_count rises by one on that edge and saturates at its maximum.
- R8: A first byte is dropped the same way when 8192 minus the frame's start address is below 4612.
- R9: A release_frame pulse lowers frame_count by one on its edge. The pulse has no effect when frame_count is 0.
- R10: A frame whose last byte comes before its sixth byte is rejected as in R4.
- R11: rd_data presents the RAM byte at rd_addr one clock edge after rd_addr is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| station_addr | input | 48 | Programmed station address; bits [47:40] are compared with the first byte |
| ind_valid | input | 1 | A receive byte is present this cycle |
| ind_first | input | 1 | Marks the first byte of a frame |
| ind_last | input | 1 | Marks the last byte of a frame |
| ind_data | input | 8 | Receive byte |
| ind_rx_stat | input | 8 | Receive flags, sampled with the last byte |
| tx_stat | input | 8 | Transmit flags, sampled with the last byte |
| rd_addr | input | 13 | Host read address |
| rd_data | output | 8 | Host read data, one cycle after rd_addr |
| release_frame | input | 1 | Host returns one frame |
| frame_count | output | 4 | Number of complete frames held |
| overflow_count | output | 16 | Frames refused for lack of room or slots |

## Verification
The overflow count and a release take effect on the edge that samples the first byte or the release pulse. The frame count rises four edges after a kept frame's last byte, and read data follows its address by one edge. A behavioural model in the bench updates on the same edges. It is compared with both counters at every falling edge, so an event one cycle early or late shows up as a mismatch. Memory contents are checked through the read port only after traffic has stopped. Each read address is set on a falling edge and the data is compared on the next falling edge, which matches the one-edge latency.

// File: rtl/rxbuf_pkg.sv
// Shared types and constants for the receive buffer manager.
// Assumes byte-wide data and a six-byte destination address.
package rxbuf_pkg;
    localparam int DA_BYTES     = 6;
    localparam int STATUS_BYTES = 4;
    localparam int LEN_W        = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR_CHECK,
        S_COPY,
        S_WRITE_STATUS,
        S_DISCARD
    } seq_state_e;
endpackage

// File: rtl/rxbuf_ram.sv
// Simple dual-port byte RAM: one synchronous write port, one registered read port.
// Assumes no reset is needed for the contents.
module rxbuf_ram #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/rxbuf_copy_filter.sv
// Destination address filter. It sees address bytes 0..5 and gives a keep
// verdict that is valid in the cycle of byte 5. Byte 0 is compared with
// station_addr[47:40]. Assumes byte_idx stays within 0..5 while byte_valid is high.
module rxbuf_copy_filter
    import rxbuf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_valid,
    input  logic [2:0]  byte_idx,
    input  logic [7:0]  byte_data,
    input  logic [47:0] station_addr,
    output logic        keep_now
);
    logic       uni_ok, bc_ok;
    logic       uni_eff, bc_eff, uni_hit, bc_hit;
    logic [7:0] station_byte;
    logic [5:0] shift;

    // Select the station byte for this index and combine it with the match history.
    always_comb begin
        shift        = 6'd40 - {byte_idx, 3'b000};
        station_byte = 8'(station_addr >> shift);
        uni_hit      = (byte_data == station_byte);
        bc_hit       = (byte_data == 8'hFF);
        uni_eff      = (byte_idx == 3'd0) ? 1'b1 : uni_ok;
        bc_eff       = (byte_idx == 3'd0) ? 1'b1 : bc_ok;
        keep_now     = (uni_eff & uni_hit) | (bc_eff & bc_hit);
    end

    // Keep the running match flags for the address bytes seen so far.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uni_ok <= 1'b0;
            bc_ok  <= 1'b0;
        end else if (byte_valid) begin
            uni_ok <= uni_eff & uni_hit;
            bc_ok  <= bc_eff & bc_hit;
        end
    end
endmodule

// File: rtl/rxbuf_sequencer.sv
// Receive sequencer. It owns the write pointer, admits or drops frames,
// rewinds rejected frames to their start and appends the status record.
// It also keeps the frame and overflow counters. Assumes frames of at most
// MAX_FRAME_BYTES bytes, at least STATUS_BYTES idle cycles between frames,
// and no first byte in the middle of a frame.
module rxbuf_sequencer
    import rxbuf_pkg::*;
#(
    parameter int ADDR_W          = 13,
    parameter int MAX_FRAMES      = 8,
    parameter int MAX_FRAME_BYTES = 4608,
    parameter int OVF_W           = 16,
    parameter int CNT_W           = $clog2(MAX_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ind_valid,
    input  logic              ind_first,
    input  logic              ind_last,
    input  logic [7:0]        ind_data,
    input  logic [7:0]        ind_rx_stat,
    input  logic [7:0]        tx_stat,
    input  logic              release_frame,
    input  logic              filt_keep,
    output logic              filt_valid,
    output logic [2:0]        filt_idx,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic [7:0]        ram_wdata,
    output logic [CNT_W-1:0]  frame_count,
    output logic [OVF_W-1:0]  overflow_count
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int RESERVE = MAX_FRAME_BYTES + STATUS_BYTES;

    seq_state_e        state;
    logic [ADDR_W-1:0] wptr, base;
    logic [LEN_W-1:0]  len;
    logic [2:0]        idx;
    logic [1:0]        st_cnt;
    logic [7:0]        rx_hold, tx_hold;

    logic [ADDR_W-1:0] start_base;
    logic [ADDR_W:0]   free_room;
    logic              admit, last_addr, status_done, do_release;

    // Decide where a new frame would start and whether it fits.
    always_comb begin
        start_base = (frame_count == '0) ? '0 : wptr;
        free_room  = (ADDR_W+1)'(DEPTH) - {1'b0, start_base};
        admit      = (frame_count < CNT_W'(MAX_FRAMES)) &&
                     (free_room >= (ADDR_W+1)'(RESERVE));
        last_addr  = (idx == 3'(DA_BYTES - 1));
        status_done = (state == S_WRITE_STATUS) && (st_cnt == 2'd3);
        do_release = release_frame && (frame_count != '0);
    end

    // Drive the filter inputs and the RAM write port.
    always_comb begin
        filt_valid = ind_valid && ((state == S_IDLE && ind_first && admit) ||
                                   state == S_ADDR_CHECK);
        filt_idx   = (state == S_IDLE) ? 3'd0 : idx;
        ram_we     = 1'b0;
        ram_waddr  = wptr;
        ram_wdata  = ind_data;
        case (state)
            S_IDLE: begin
                ram_we    = ind_valid && ind_first && admit;
                ram_waddr = start_base;
            end
            S_ADDR_CHECK, S_COPY: ram_we = ind_valid;
            S_WRITE_STATUS: begin
                ram_we = 1'b1;
                case (st_cnt)
                    2'd0:    ram_wdata = len[7:0];
                    2'd1:    ram_wdata = len[15:8];
                    2'd2:    ram_wdata = rx_hold;
                    default: ram_wdata = tx_hold;
                endcase
            end
            default: ram_we = 1'b0;
        endcase
    end

    // Sequencer state, write pointer, rollback point and frame length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            wptr    <= '0;
            base    <= '0;
            len     <= '0;
            idx     <= '0;
            st_cnt  <= '0;
            rx_hold <= '0;
            tx_hold <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (ind_valid && ind_first && admit) begin
                        base <= start_base;
                        len  <= LEN_W'(1);
                        idx  <= 3'd1;
                        if (ind_last) begin
                            wptr <= start_base;
                        end else begin
                            wptr  <= start_base + ADDR_W'(1);
                            state <= S_ADDR_CHECK;
                        end
                    end else if (ind_valid && ind_first && !ind_last) begin
                        state <= S_DISCARD;
                    end
                end
                S_ADDR_CHECK: begin
                    if (ind_valid) begin
                        len <= len + LEN_W'(1);
                        idx <= idx + 3'd1;
                        if (last_addr && filt_keep) begin
                            wptr <= wptr + ADDR_W'(1);
                            if (ind_last) begin
                                rx_hold <= ind_rx_stat;
                                tx_hold <= tx_stat;
                                st_cnt  <= '0;
                                state   <= S_WRITE_STATUS;
                            end else begin
                                state <= S_COPY;
                            end
                        end else if (last_addr || ind_last) begin
                            wptr  <= base;
                            state <= ind_last ? S_IDLE : S_DISCARD;
                        end else begin
                            wptr <= wptr + ADDR_W'(1);
                        end
                    end
                end
                S_COPY: begin
                    if (ind_valid) begin
                        wptr <= wptr + ADDR_W'(1);
                        len  <= len + LEN_W'(1);
                        if (ind_last) begin
                            rx_hold <= ind_rx_stat;
                            tx_hold <= tx_stat;
                            st_cnt  <= '0;
                            state   <= S_WRITE_STATUS;
                        end
                    end
                end
                S_WRITE_STATUS: begin
                    wptr   <= wptr + ADDR_W'(1);
                    st_cnt <= st_cnt + 2'd1;
                    if (st_cnt == 2'd3) state <= S_IDLE;
                end
                S_DISCARD: begin
                    if (ind_valid && ind_last) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Held-frame counter: up after a status record, down on a host release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_count <= '0;
        end else begin
            frame_count <= frame_count + CNT_W'(status_done) - CNT_W'(do_release);
        end
    end

    // Saturating count of frames refused at their first byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow_count <= '0;
        end else if (state == S_IDLE && ind_valid && ind_first && !admit &&
                     overflow_count != '1) begin
            overflow_count <= overflow_count + OVF_W'(1);
        end
    end

    // R7: the number of held frames never exceeds the slot limit.
    assert_frame_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_count <= CNT_W'(MAX_FRAMES));

    // R4: a reject on the last address byte returns the pointer to the frame start.
    assert_rollback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR_CHECK && ind_valid && last_addr && !filt_keep)
        |=> (wptr == $past(base)));

    // R4: nothing of a discarded frame reaches the RAM.
    assert_no_write_discard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DISCARD) |-> !ram_we);

    // R6: the frame counter only rises from the last status write.
    assert_count_after_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_count == $past(frame_count) + CNT_W'(1)) |-> ($past(state) == S_WRITE_STATUS));

    // R7: the overflow counter only moves when a first byte arrives while idle.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_count != $past(overflow_count))
        |-> ($past(state) == S_IDLE && $past(ind_valid) && $past(ind_first)));
endmodule

// File: rtl/rx_buffer_mgr.sv
// Top level of the receive buffer manager: copy filter, receive sequencer
// and receive RAM. Assumes the framing rules stated for the sequencer.
module rx_buffer_mgr #(
    parameter int ADDR_W          = 13,
    parameter int MAX_FRAMES      = 8,
    parameter int MAX_FRAME_BYTES = 4608,
    parameter int OVF_W           = 16,
    parameter int CNT_W           = $clog2(MAX_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [47:0]       station_addr,
    input  logic              ind_valid,
    input  logic              ind_first,
    input  logic              ind_last,
    input  logic [7:0]        ind_data,
    input  logic [7:0]        ind_rx_stat,
    input  logic [7:0]        tx_stat,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              release_frame,
    output logic [CNT_W-1:0]  frame_count,
    output logic [OVF_W-1:0]  overflow_count
);
    logic              filt_valid, filt_keep;
    logic [2:0]        filt_idx;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [7:0]        ram_wdata;

    rxbuf_copy_filter u_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_valid   (filt_valid),
        .byte_idx     (filt_idx),
        .byte_data    (ind_data),
        .station_addr (station_addr),
        .keep_now     (filt_keep)
    );

    rxbuf_sequencer #(
        .ADDR_W          (ADDR_W),
        .MAX_FRAMES      (MAX_FRAMES),
        .MAX_FRAME_BYTES (MAX_FRAME_BYTES),
        .OVF_W           (OVF_W),
        .CNT_W           (CNT_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .ind_valid      (ind_valid),
        .ind_first      (ind_first),
        .ind_last       (ind_last),
        .ind_data       (ind_data),
        .ind_rx_stat    (ind_rx_stat),
        .tx_stat        (tx_stat),
        .release_frame  (release_frame),
        .filt_keep      (filt_keep),
        .filt_valid     (filt_valid),
        .filt_idx       (filt_idx),
        .ram_we         (ram_we),
        .ram_waddr      (ram_waddr),
        .ram_wdata      (ram_wdata),
        .frame_count    (frame_count),
        .overflow_count (overflow_count)
    );

    rxbuf_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: tb/sim_rx_buffer_mgr.sv
module sim_rx_buffer_mgr;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8192;
    localparam int RESERVE    = 4612;
    localparam int WDOG       = 150000;
    localparam logic [47:0] STATION = 48'h0210_5A3C_7E01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] station_addr = STATION;
    logic        ind_valid = 1'b0, ind_first = 1'b0, ind_last = 1'b0;
    logic [7:0]  ind_data = '0, ind_rx_stat = '0, tx_stat = '0;
    logic [12:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic        release_frame = 1'b0;
    logic [3:0]  frame_count;
    logic [15:0] overflow_count;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    rx_buffer_mgr u0 (
        .clk(clk), .rst_n(rst_n), .station_addr(station_addr),
        .ind_valid(ind_valid), .ind_first(ind_first), .ind_last(ind_last),
        .ind_data(ind_data), .ind_rx_stat(ind_rx_stat), .tx_stat(tx_stat),
        .rd_addr(rd_addr), .rd_data(rd_data), .release_frame(release_frame),
        .frame_count(frame_count), .overflow_count(overflow_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [7:0] mmem [DEPTH];
    int  m_count = 0, m_ovf = 0, m_wp = 0, m_base = 0, m_tmr = 0;
    bit  m_admit = 0;
    byte unsigned cur[$];

    function automatic bit da_ok();
        bit uni = 1, bc = 1;
        for (int i = 0; i < 6; i++) begin
            if (cur[i] != STATION[8*(5-i) +: 8]) uni = 0;
            if (cur[i] != 8'hFF) bc = 0;
        end
        return uni | bc;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 0; m_ovf = 0; m_wp = 0; m_tmr = 0; m_admit = 0;
            cur.delete();
        end else begin
            int old, inc;
            old = m_count;
            inc = 0;
            if (m_tmr > 0) begin
                m_tmr--;
                if (m_tmr == 0) inc = 1;
            end
            m_count = old + inc - ((release_frame && old > 0) ? 1 : 0);
            if (ind_valid) begin
                if (ind_first) begin
                    m_base  = (old == 0) ? 0 : m_wp;
                    m_admit = (old < 8) && (DEPTH - m_base >= RESERVE);
                    if (!m_admit && m_ovf < 65535) m_ovf++;
                    cur.delete();
                end
                if (m_admit) cur.push_back(ind_data);
                if (ind_last) begin
                    if (m_admit && cur.size() >= 6 && da_ok()) begin
                        int n;
                        n = cur.size();
                        for (int i = 0; i < n; i++) mmem[m_base + i] = cur[i];
                        mmem[m_base + n]     = 8'(n);
                        mmem[m_base + n + 1] = 8'(n >> 8);
                        mmem[m_base + n + 2] = ind_rx_stat;
                        mmem[m_base + n + 3] = tx_stat;
                        m_wp  = m_base + n + 4;
                        m_tmr = 4;
                    end
                    m_admit = 0;
                end
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Counter comparison against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 R9 frame_count", int'(frame_count), m_count);
            check("R7 R8 overflow_count", int'(overflow_count), m_ovf);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_frame(logic [47:0] da, int len, int seed, logic [7:0] rxf, logic [7:0] txf);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            ind_valid   = 1'b1;
            ind_first   = (i == 0);
            ind_last    = (i == len - 1);
            ind_data    = (i < 6) ? da[8*(5-i) +: 8] : 8'(seed + i * 7);
            ind_rx_stat = rxf;
            tx_stat     = txf;
        end
        @(negedge clk);
        ind_valid = 1'b0; ind_first = 1'b0; ind_last = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic release_one();
        @(negedge clk);
        release_frame = 1'b1;
        @(negedge clk);
        release_frame = 1'b0;
    endtask

    task automatic read_check(int addr, int exp, string tag);
        @(negedge clk);
        rd_addr = 13'(addr);
        @(negedge clk);
        check(tag, int'(rd_data), exp);
    endtask

    // R2 R11: compare every stored byte up to the model's write pointer.
    task automatic verify_region();
        for (int a = 0; a < m_wp; a++) read_check(a, int'(mmem[a]), "R2 R11 ram readback");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 frame_count at reset", int'(frame_count), 0);
        check("R1 overflow_count at reset", int'(overflow_count), 0);
        rst_n = 1'b1;

        // R3: unicast frame of 20 bytes at address 0.
        send_frame(STATION, 20, 3, 8'hA5, 8'h3C);
        // R5: status record follows the data.
        read_check(20, 20, "R5 length low");
        read_check(21, 0, "R5 length high");
        read_check(22, 8'hA5, "R5 rx flags");
        read_check(23, 8'h3C, "R5 tx flags");
        // R3: broadcast frame, starts at 24.
        send_frame(48'hFFFF_FFFF_FFFF, 10, 9, 8'h01, 8'h02);
        // R3 R4: mismatch in the first byte and in the last address byte.
        send_frame(48'h0310_5A3C_7E01, 30, 5, 8'h00, 8'h00);
        send_frame(48'h0210_5A3C_7E00, 12, 6, 8'h00, 8'h00);
        send_frame(48'hFFFF_FFFF_FFFE, 9, 7, 8'h00, 8'h00);
        // R10: short frame with a matching prefix.
        send_frame(STATION, 4, 8, 8'h00, 8'h00);
        check("R3 R4 R10 rejects leave count", int'(frame_count), 2);
        // R4: next kept frame starts where the rejects began (24+10+4).
        send_frame(STATION, 15, 11, 8'h44, 8'h55);
        read_check(38, 8'h02, "R4 kept frame at rollback address");
        read_check(39, 8'h10, "R4 second byte at rollback address");
        read_check(38 + 15, 15, "R5 length of rolled-back frame");
        // Exactly six-byte frame ending on the decision byte.
        send_frame(STATION, 6, 0, 8'h66, 8'h77);
        // R7: fill to eight frames, then one more is refused.
        for (int k = 0; k < 4; k++) send_frame(STATION, 8 + k, 20 + k, 8'(k), 8'(k + 1));
        check("R7 eight frames held", int'(frame_count), 8);
        send_frame(STATION, 10, 40, 8'h00, 8'h00);
        check("R7 overflow after limit", int'(overflow_count), 1);
        check("R7 count stays at limit", int'(frame_count), 8);
        verify_region();

        // R9: releases, with one extra at zero ignored.
        for (int k = 0; k < 3; k++) release_one();
        check("R9 count after three releases", int'(frame_count), 5);
        for (int k = 0; k < 6; k++) release_one();
        check("R9 release at zero ignored", int'(frame_count), 0);

        // R8: large frame from address 0 leaves too little room for another.
        send_frame(STATION, 3600, 13, 8'h5A, 8'hC3);
        read_check(0, 8'h02, "R2 restart at address 0");
        send_frame(STATION, 10, 50, 8'h00, 8'h00);
        check("R8 overflow for lack of room", int'(overflow_count), 2);
        check("R8 count unchanged", int'(frame_count), 1);
        verify_region();
        release_one();
        send_frame(48'hFFFF_FFFF_FFFF, 16, 60, 8'h11, 8'h22);
        check("R8 accepted again after release", int'(frame_count), 1);
        verify_region();

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule